// File: doc/BRIEF.md
# Host Access Ready Arbiter

This block sits between an 8-bit host register port and the core of a scan controller. It decodes each host read or write by register address. It checks the target register against the blocking conditions that the core's status flags report. If the access can proceed, the block keeps `host_ready` high and pulses the matching core enable in the same cycle. If the access cannot proceed, it pulls `host_ready` low for as long as the condition lasts. During that time the host holds its strobe, address and data steady. The access completes in the first cycle in which the condition has cleared.

Four rules can block an access:
- A read of the input-data buffer is blocked while that buffer is empty.
- A write to the output-data buffer is blocked while that buffer is full or being reset.
- A write to the command register, either configuration register or the counter register is blocked while a command is running. A command write that sets the software-reset bit is the one exception.
- During a full-duplex scan with a nonzero retiming delay, a write to the output-data buffer is blocked once writes lead input-buffer reads by the allowed margin.

A saturating lead counter tracks that margin. It is cleared when each scan command starts.

Status and command reads are never blocked, so a host without wait-state support can poll for readiness instead.

Top module: `host_wait_arbiter`

## Requirements
- R1: During and after reset, with no strobe asserted, `host_ready` is high and neither core enable is asserted. Reset clears the lead counter to zero.
- R2: A read of the input-data buffer (address 5) is blocked while `din_empty` is high. The read completes in the first cycle in which `din_empty` is low.
- R3: A write to the output-data buffer (address 6) is blocked while `dout_full` or `dout_clearing` is high.
- R4: While `cmd_opcode` is nonzero, writes to the command (address 1), configuration A (address 2), configuration B (address 3) and counter (address 4) registers are blocked until the opcode returns to zero.
- R5: A command-register write with write-data bit 7 set is granted in the same cycle, whatever the opcode.
- R6: Reads of the status (address 0) and command registers are never blocked. Accesses with no matching rule are never blocked: all other reads, writes to status, din or spare addresses, and reads of dout.
- R7: While `duplex_scan` is high and `retime_cnt` is nonzero, a write to the output-data buffer is blocked when the lead count is 5 or more. It is not blocked when either condition is absent.
- R8: The lead counter returns to zero on `scan_start`. Otherwise it increases by one on each granted output-buffer write and decreases by one on each granted input-buffer read. It saturates at its upper end and does not go below zero.
- R9: While a blocked access is held, `host_ready` and the core enables stay low. The matching enable is asserted exactly in the cycle in which `host_ready` returns high, so each held access is performed once. A host that drops its strobe abandons the access.
- R10: In every cycle with a strobe, `host_ready` equals the core enable of that strobe. Each cycle with a strobe and `host_ready` high is one completed access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 3 | Host register address |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| din_empty | input | 1 | Input-data buffer empty |
| dout_full | input | 1 | Output-data buffer full |
| dout_clearing | input | 1 | Output-data buffer reset in progress |
| cmd_opcode | input | 4 | Opcode field of the running command, zero when idle |
| scan_start | input | 1 | One-cycle pulse when a scan command begins |
| duplex_scan | input | 1 | A full-duplex scan is running |
| retime_cnt | input | 4 | Retiming-delay bit count of the running scan |
| host_ready | output | 1 | High when the current access is granted |
| core_rd_en | output | 1 | Perform the decoded register read this cycle |
| core_wr_en | output | 1 | Perform the decoded register write this cycle |

## Verification
The bench uses the default parameters: a 3-bit address space, a 4-bit opcode, a 4-bit retiming count and a lead limit of 5. With a limit of 5, the lead-blocking threshold is reached after five granted writes. The bench can therefore hit the threshold several times, step back below it with one read, and exceed it while the retiming count is zero. The 4-bit opcode lets the bench apply its lowest, highest and scattered nonzero values against every interlocked register.

// File: rtl/hwa_pkg.sv
// Package: shared types for the host access ready arbiter.
// Assumes the seven decoded registers listed below; the bit order of
// reg_hit_t matches the decode map index (dout is bit 0).
package hwa_pkg;

    // One-hot address decode result, one bit per guarded register
    typedef struct packed {
        logic status;
        logic cmd;
        logic cfga;
        logic cfgb;
        logic cnt;
        logic din;
        logic dout;
    } reg_hit_t;

    localparam int NUM_REGS = 7;

endpackage

// File: rtl/hwa_decode.sv
// Module: hwa_decode
// Compares the host address against each register address and returns
// a one-hot hit vector. Assumes all register addresses are distinct;
// an address matching none of them yields an all-zero hit.
module hwa_decode
    import hwa_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int A_STATUS = 0,
    parameter int A_CMD    = 1,
    parameter int A_CFGA   = 2,
    parameter int A_CFGB   = 3,
    parameter int A_CNT    = 4,
    parameter int A_DIN    = 5,
    parameter int A_DOUT   = 6
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_hit_t          hit_o
);

    // index order follows reg_hit_t from its least significant bit upward
    localparam int MAP [NUM_REGS] = '{A_DOUT, A_DIN, A_CNT, A_CFGB,
                                      A_CFGA, A_CMD, A_STATUS};

    logic [NUM_REGS-1:0] hv;

    // one address comparator per register
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cmp
        assign hv[g] = (addr_i == ADDR_W'(MAP[g]));
    end

    assign hit_o = reg_hit_t'(hv);

endmodule

// File: rtl/hwa_rules.sv
// Module: hwa_rules
// Combinational blocking rules. Given the decoded target, the strobe
// direction and the core flags, it reports whether the access must wait.
// Assumes rd_i and wr_i are never both high.
module hwa_rules
    import hwa_pkg::*;
#(
    parameter int OPC_W = 4
) (
    input  reg_hit_t         hit_i,
    input  logic             rd_i,
    input  logic             wr_i,
    input  logic             swrst_bit_i,
    input  logic             din_empty_i,
    input  logic             dout_full_i,
    input  logic             dout_clearing_i,
    input  logic [OPC_W-1:0] opcode_i,
    input  logic             lead_limit_i,
    output logic             blocked_o
);

    logic busy;
    logic blk_din;
    logic blk_dout;
    logic blk_cfg;

    // evaluate each rule independently, then combine
    always_comb begin
        busy     = |opcode_i;
        blk_din  = rd_i && hit_i.din && din_empty_i;
        blk_dout = wr_i && hit_i.dout &&
                   (dout_full_i || dout_clearing_i || lead_limit_i);
        blk_cfg  = wr_i && busy &&
                   ((hit_i.cmd && !swrst_bit_i) || hit_i.cfga ||
                    hit_i.cfgb || hit_i.cnt);
        blocked_o = blk_din || blk_dout || blk_cfg;
    end

endmodule

// File: rtl/hwa_lead_counter.sv
// Module: hwa_lead_counter
// Tracks how far output-buffer writes run ahead of input-buffer reads.
// Clear wins over counting; the count saturates at its width and floors
// at zero. The limit flag is raised only during a full-duplex scan with a
// nonzero retiming delay.
module hwa_lead_counter #(
    parameter int LEAD_MAX = 5,
    parameter int RDLY_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              inc_i,
    input  logic              dec_i,
    input  logic              duplex_i,
    input  logic [RDLY_W-1:0] retime_i,
    output logic              at_limit_o
);

    localparam int LEAD_W = $clog2(LEAD_MAX + 2) + 1;
    localparam logic [LEAD_W-1:0] LIMIT = LEAD_W'(LEAD_MAX);

    logic [LEAD_W-1:0] lead_q;
    logic              limit_on;

    // update the lead count on granted buffer accesses
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            lead_q <= '0;
        end else if (inc_i && !dec_i) begin
            if (lead_q != '1) lead_q <= lead_q + 1'b1;
        end else if (dec_i && !inc_i) begin
            if (lead_q != '0) lead_q <= lead_q - 1'b1;
        end
    end

    // flag a write that would exceed the allowed lead
    always_comb begin
        limit_on   = duplex_i && (retime_i != '0);
        at_limit_o = limit_on && (lead_q >= LIMIT);
    end

    // R7: no output write is counted while the limit is active and reached
    assert_lead_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_on && lead_q >= LIMIT) |-> !inc_i);

    // R8: a scan start leaves the lead at zero on the next cycle
    assert_lead_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (lead_q == '0));

endmodule

// File: rtl/hwa_grant_ctrl.sv
// Module: hwa_grant_ctrl
// Pending-access handshake. Drives ready and the core enables from the
// block decision and records whether a blocked access is outstanding.
// Assumes the host keeps strobe, address and data steady while waiting;
// dropping the strobe abandons the access.
module hwa_grant_ctrl #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              blocked_i,
    output logic              ready_o,
    output logic              rd_en_o,
    output logic              wr_en_o
);

    logic req;
    logic pend_q;

    // grant in the same cycle whenever nothing blocks
    always_comb begin
        req     = rd_i || wr_i;
        ready_o = !(req && blocked_i);
        rd_en_o = rd_i && !blocked_i;
        wr_en_o = wr_i && !blocked_i;
    end

    // remember an access left waiting at this edge
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= req && blocked_i;
    end

    // R9: a held access keeps its address steady
    assert_hold_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && req) |-> $stable(addr_i));

    // R9: a held write keeps its data steady
    assert_hold_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && wr_i) |-> $stable(wdata_i));

    // R10: never both enables, never both strobes
    assert_one_dir_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_i && wr_i) && !(rd_en_o && wr_en_o));

endmodule

// File: rtl/host_wait_arbiter.sv
// Module: host_wait_arbiter (top)
// Guards an 8-bit host register port in front of a scan-controller core.
// Decodes each access, applies the blocking rules and holds ready low until
// the access may complete. Assumes one strobe at a time and a host that
// keeps its access steady while ready is low.
module host_wait_arbiter #(
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 8,
    parameter int OPC_W     = 4,
    parameter int RDLY_W    = 4,
    parameter int LEAD_MAX  = 5,
    parameter int SWRST_BIT = 7,
    parameter int A_STATUS  = 0,
    parameter int A_CMD     = 1,
    parameter int A_CFGA    = 2,
    parameter int A_CFGB    = 3,
    parameter int A_CNT     = 4,
    parameter int A_DIN     = 5,
    parameter int A_DOUT    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              din_empty,
    input  logic              dout_full,
    input  logic              dout_clearing,
    input  logic [OPC_W-1:0]  cmd_opcode,
    input  logic              scan_start,
    input  logic              duplex_scan,
    input  logic [RDLY_W-1:0] retime_cnt,
    output logic              host_ready,
    output logic              core_rd_en,
    output logic              core_wr_en
);
    import hwa_pkg::*;

    reg_hit_t hit;
    logic     blocked;
    logic     lead_limit;
    logic     lead_inc;
    logic     lead_dec;

    hwa_decode #(
        .ADDR_W(ADDR_W), .A_STATUS(A_STATUS), .A_CMD(A_CMD),
        .A_CFGA(A_CFGA), .A_CFGB(A_CFGB), .A_CNT(A_CNT),
        .A_DIN(A_DIN), .A_DOUT(A_DOUT)
    ) u_decode (
        .addr_i (host_addr),
        .hit_o  (hit)
    );

    hwa_rules #(.OPC_W(OPC_W)) u_rules (
        .hit_i           (hit),
        .rd_i            (host_rd),
        .wr_i            (host_wr),
        .swrst_bit_i     (host_wdata[SWRST_BIT]),
        .din_empty_i     (din_empty),
        .dout_full_i     (dout_full),
        .dout_clearing_i (dout_clearing),
        .opcode_i        (cmd_opcode),
        .lead_limit_i    (lead_limit),
        .blocked_o       (blocked)
    );

    hwa_grant_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_grant (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_i      (host_rd),
        .wr_i      (host_wr),
        .addr_i    (host_addr),
        .wdata_i   (host_wdata),
        .blocked_i (blocked),
        .ready_o   (host_ready),
        .rd_en_o   (core_rd_en),
        .wr_en_o   (core_wr_en)
    );

    // count only accesses that really reach a buffer
    always_comb begin
        lead_inc = core_wr_en && hit.dout;
        lead_dec = core_rd_en && hit.din;
    end

    hwa_lead_counter #(.LEAD_MAX(LEAD_MAX), .RDLY_W(RDLY_W)) u_lead (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (scan_start),
        .inc_i      (lead_inc),
        .dec_i      (lead_dec),
        .duplex_i   (duplex_scan),
        .retime_i   (retime_cnt),
        .at_limit_o (lead_limit)
    );

    // R2: no input-buffer read reaches the core while it is empty
    assert_din_guard_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_rd_en && host_addr == ADDR_W'(A_DIN) && din_empty));

    // R3: no output-buffer write reaches the core while full or resetting
    assert_dout_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_wr_en && host_addr == ADDR_W'(A_DOUT) &&
          (dout_full || dout_clearing)));

    // R4: interlocked registers are not written while a command runs
    assert_busy_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (core_wr_en && cmd_opcode != '0) |->
        !(host_addr == ADDR_W'(A_CFGA) || host_addr == ADDR_W'(A_CFGB) ||
          host_addr == ADDR_W'(A_CNT) ||
          (host_addr == ADDR_W'(A_CMD) && !host_wdata[SWRST_BIT])));

    // R5: software reset write always goes through
    assert_swrst_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == ADDR_W'(A_CMD) && host_wdata[SWRST_BIT])
        |-> (host_ready && core_wr_en));

    // R6: polling reads of status and command never wait
    assert_poll_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && (host_addr == ADDR_W'(A_STATUS) ||
                     host_addr == ADDR_W'(A_CMD))) |-> (host_ready && core_rd_en));

    // R10: ready tracks the enable of the active strobe
    assert_ready_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd || host_wr) |-> (host_ready == (core_rd_en || core_wr_en)));

endmodule

// File: tb/tb_host_wait_arbiter.sv
module tb_host_wait_arbiter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] host_addr = '0;
    logic       host_rd = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic       din_empty = 1'b0;
    logic       dout_full = 1'b0;
    logic       dout_clearing = 1'b0;
    logic [3:0] cmd_opcode = '0;
    logic       scan_start = 1'b0;
    logic       duplex_scan = 1'b0;
    logic [3:0] retime_cnt = '0;
    logic       host_ready;
    logic       core_rd_en;
    logic       core_wr_en;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    host_wait_arbiter dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .din_empty(din_empty),
        .dout_full(dout_full), .dout_clearing(dout_clearing),
        .cmd_opcode(cmd_opcode), .scan_start(scan_start),
        .duplex_scan(duplex_scan), .retime_cnt(retime_cnt),
        .host_ready(host_ready), .core_rd_en(core_rd_en),
        .core_wr_en(core_wr_en)
    );

    typedef struct packed {
        logic [2:0] addr;
        logic       rd;
        logic       wr;
        logic [7:0] wd;
        logic       emp;
        logic       full;
        logic       clr;
        logic [3:0] opc;
        logic       erdy;
        logic       erd;
        logic       ewr;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{3'd5,1'b1,1'b0,8'h00,1'b1,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0,4'd2}, // R2 empty
        '{3'd5,1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,4'h0,1'b1,1'b1,1'b0,4'd2}, // R2 data
        '{3'd6,1'b0,1'b1,8'h3C,1'b0,1'b1,1'b0,4'h0,1'b0,1'b0,1'b0,4'd3}, // R3 full
        '{3'd6,1'b0,1'b1,8'h3C,1'b0,1'b0,1'b1,4'h0,1'b0,1'b0,1'b0,4'd3}, // R3 clearing
        '{3'd6,1'b0,1'b1,8'h3C,1'b0,1'b0,1'b0,4'h0,1'b1,1'b0,1'b1,4'd3}, // R3 free
        '{3'd1,1'b0,1'b1,8'h01,1'b0,1'b0,1'b0,4'h3,1'b0,1'b0,1'b0,4'd4}, // R4 cmd
        '{3'd2,1'b0,1'b1,8'hAA,1'b0,1'b0,1'b0,4'h1,1'b0,1'b0,1'b0,4'd4}, // R4 cfga
        '{3'd3,1'b0,1'b1,8'h55,1'b0,1'b0,1'b0,4'h8,1'b0,1'b0,1'b0,4'd4}, // R4 cfgb
        '{3'd4,1'b0,1'b1,8'h10,1'b0,1'b0,1'b0,4'hF,1'b0,1'b0,1'b0,4'd4}, // R4 counter
        '{3'd2,1'b0,1'b1,8'hAA,1'b0,1'b0,1'b0,4'h0,1'b1,1'b0,1'b1,4'd4}, // R4 idle
        '{3'd1,1'b0,1'b1,8'h80,1'b0,1'b0,1'b0,4'h5,1'b1,1'b0,1'b1,4'd5}, // R5 swrst
        '{3'd1,1'b0,1'b1,8'hFF,1'b0,1'b0,1'b0,4'h1,1'b1,1'b0,1'b1,4'd5}, // R5 swrst+op
        '{3'd0,1'b1,1'b0,8'h00,1'b1,1'b1,1'b0,4'h2,1'b1,1'b1,1'b0,4'd6}, // R6 status rd
        '{3'd1,1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,4'h9,1'b1,1'b1,1'b0,4'd6}, // R6 cmd rd
        '{3'd7,1'b0,1'b1,8'h77,1'b0,1'b1,1'b0,4'h3,1'b1,1'b0,1'b1,4'd6}, // R6 spare wr
        '{3'd3,1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,4'h4,1'b1,1'b1,1'b0,4'd6}, // R6 cfgb rd
        '{3'd5,1'b0,1'b1,8'h12,1'b1,1'b0,1'b0,4'h0,1'b1,1'b0,1'b1,4'd6}, // R6 din wr
        '{3'd6,1'b1,1'b0,8'h00,1'b0,1'b1,1'b0,4'h0,1'b1,1'b1,1'b0,4'd6}  // R6 dout rd
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        host_rd = 1'b0;
        host_wr = 1'b0;
    endtask

    // one cycle attempt: drive after an edge, check mid-cycle, release
    task automatic attempt(input logic [2:0] a, input logic rd, input logic wr,
                           input logic [7:0] d, input logic erdy, input string tag);
        @(posedge clk); #1;
        host_addr = a; host_rd = rd; host_wr = wr; host_wdata = d;
        @(negedge clk);
        chk({tag, " ready"}, {7'd0, host_ready}, {7'd0, erdy});
        chk({tag, " enable"}, {6'd0, core_rd_en, core_wr_en},
            {6'd0, rd & erdy, wr & erdy});
        @(posedge clk); #1;
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int wcount;
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 ready in reset", {7'd0, host_ready}, 8'd1);
        chk("R1 enables in reset", {6'd0, core_rd_en, core_wr_en}, 8'd0);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", {7'd0, host_ready}, 8'd1);

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(posedge clk); #1;
            host_addr = VECS[i].addr; host_rd = VECS[i].rd; host_wr = VECS[i].wr;
            host_wdata = VECS[i].wd; din_empty = VECS[i].emp;
            dout_full = VECS[i].full; dout_clearing = VECS[i].clr;
            cmd_opcode = VECS[i].opc;
            @(negedge clk);
            chk($sformatf("R%0d vec%0d ready", VECS[i].req, i),
                {7'd0, host_ready}, {7'd0, VECS[i].erdy});
            chk($sformatf("R%0d vec%0d enables", VECS[i].req, i),
                {6'd0, core_rd_en, core_wr_en}, {6'd0, VECS[i].erd, VECS[i].ewr});
            @(posedge clk); #1;
            idle();
        end
        din_empty = 1'b0; dout_full = 1'b0; dout_clearing = 1'b0; cmd_opcode = '0;

        // R1: mid-run reset clears the lead (table left it at 1)
        @(posedge clk); #1; rst_n = 1'b0;
        @(posedge clk); #1; rst_n = 1'b1;
        duplex_scan = 1'b1; retime_cnt = 4'd3;
        for (int k = 0; k < 5; k++) attempt(3'd6, 1'b0, 1'b1, 8'h01, 1'b1, "R1 lead after reset");
        // R7: sixth write exceeds the lead
        attempt(3'd6, 1'b0, 1'b1, 8'h02, 1'b0, "R7 lead limit");
        // R8: one read drops the lead, one more write fits
        attempt(3'd5, 1'b1, 1'b0, 8'h00, 1'b1, "R8 din read");
        attempt(3'd6, 1'b0, 1'b1, 8'h03, 1'b1, "R8 write after read");
        attempt(3'd6, 1'b0, 1'b1, 8'h04, 1'b0, "R7 limit again");
        // R7: zero retiming removes the limit
        retime_cnt = 4'd0;
        attempt(3'd6, 1'b0, 1'b1, 8'h05, 1'b1, "R7 zero retime");
        retime_cnt = 4'd2;
        attempt(3'd6, 1'b0, 1'b1, 8'h06, 1'b0, "R7 over limit");
        duplex_scan = 1'b0;
        attempt(3'd6, 1'b0, 1'b1, 8'h07, 1'b1, "R7 not duplex");
        // R8: scan start clears the lead
        @(posedge clk); #1; scan_start = 1'b1;
        @(posedge clk); #1; scan_start = 1'b0; duplex_scan = 1'b1;
        for (int k = 0; k < 5; k++) attempt(3'd6, 1'b0, 1'b1, 8'h08, 1'b1, "R8 after scan start");
        attempt(3'd6, 1'b0, 1'b1, 8'h09, 1'b0, "R8 limit after clear");
        duplex_scan = 1'b0; retime_cnt = '0;

        // R9: held output write completes once when full clears
        dout_full = 1'b1; wcount = 0;
        @(posedge clk); #1;
        host_addr = 3'd6; host_wr = 1'b1; host_wdata = 8'hC3;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (core_wr_en) wcount++;
            chk("R9 held ready low", {7'd0, host_ready}, 8'd0);
            @(posedge clk); #1;
        end
        dout_full = 1'b0;
        @(negedge clk);
        if (core_wr_en) wcount++;
        chk("R9 ready returns", {7'd0, host_ready}, 8'd1);
        @(posedge clk); #1; idle();
        @(negedge clk);
        if (core_wr_en) wcount++;
        chk("R9 single completion", wcount[7:0], 8'd1);

        // R2: held input read completes when data arrives
        din_empty = 1'b1;
        @(posedge clk); #1;
        host_addr = 3'd5; host_rd = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R2 held read", {6'd0, host_ready, core_rd_en}, 8'd0);
            @(posedge clk); #1;
        end
        din_empty = 1'b0;
        @(negedge clk);
        chk("R2 read completes", {6'd0, host_ready, core_rd_en}, 8'd3);
        @(posedge clk); #1; idle();

        // R4: held configuration write completes when command ends
        cmd_opcode = 4'h6;
        @(posedge clk); #1;
        host_addr = 3'd4; host_wr = 1'b1; host_wdata = 8'h44;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R4 held cfg write", {6'd0, host_ready, core_wr_en}, 8'd0);
            @(posedge clk); #1;
        end
        cmd_opcode = 4'h0;
        @(negedge clk);
        chk("R4 cfg write completes", {6'd0, host_ready, core_wr_en}, 8'd3);
        @(posedge clk); #1; idle();

        // R10: idle port stays ready with no enables
        @(negedge clk);
        chk("R10 idle", {5'd0, host_ready, core_rd_en, core_wr_en}, 8'd4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule